// File: doc/BRIEF.md
# Register-Immediate Integer ALU with Set-Compare

This block is the integer arithmetic-logic unit of a small three-format load/store processor. It takes two 32-bit operands and a 6-bit function code. The second operand is either a register value or a 16-bit immediate that the caller has already widened. Arithmetic immediates are sign-extended before they arrive. Logical immediates are zero-extended. The unit returns a 32-bit result and a signed-overflow indication. It covers addition, subtraction, the three bitwise operations, three shifts, a load-upper-half operation and six compare-and-set operations.

The core is combinational, with control decode and datapath kept in separate modules. A thin registered stage sits around it and is qualified by a valid strobe, so every result appears on the port one clock after its request. When overflow is flagged, the result port still carries the wrapped value, and the consumer decides whether to suppress the write-back.

Top module: `alu_ri_top`

## Requirements
- R1: Function code 000100 returns A+B and code 000110 returns A-B, both truncated to 32 bits (wrapped).
- R2: `overflow` is 1 only for codes 000100 and 000110, and only when the result in two's complement is not representable in 32 signed bits. Every other code gives `overflow` 0.
- R3: Code 001000 returns A AND B, 001001 returns A OR B and 001010 returns A XOR B.
- R4: Code 001100 shifts A left and code 001110 shifts A right, both filling with zeros. The shift amount is B[4:0], and B[31:5] has no effect.
- R5: Code 001111 shifts A right by B[4:0] and fills the vacated bits with A[31].
- R6: Codes 010000 (equal), 010010 (not equal), 010100 (less), 010110 (less or equal), 011000 (greater) and 011010 (greater or equal) compare A with B as signed values. Each returns exactly 32'h0000_0001 when its condition holds and 32'h0000_0000 otherwise.
- R7: Code 011011 returns B[15:0] in result bits 31:16 and zeros in bits 15:0.
- R8: Code 000000 (no operation) and any code not listed above return 0 with `overflow` 0.
- R9: `outValid` equals `inValid` delayed by one clock. `result` and `overflow` for a request sampled at one rising edge are shown after the next edge.
- R10: Reset drives `outValid`, `result` and `overflow` to 0. While `inValid` is 0, `result` and `overflow` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe for this cycle's operands |
| opCode | input | 6 | Function code |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Second operand, register value or pre-extended immediate |
| outValid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Registered result |
| overflow | output | 1 | Registered signed-overflow flag |

## Verification
Every result and overflow flag is due exactly one clock after the request is sampled. The driver applies each request at a falling edge and puts the independently modelled answer into a queue. The monitor reads the outputs at every falling edge, so it sees the value registered at the rising edge just before. Each time it sees `outValid`, it takes the oldest queue entry and compares against it. A valid output with an empty queue is an error, as is any entry left in the queue at the end. On cycles without `outValid`, the monitor confirms that the outputs have not moved since the last result.

// File: rtl/alu_ri_pkg.sv
package alu_ri_pkg;

  localparam int OP_W = 6;

  // Function codes; values are fixed by the instruction encoding
  localparam logic [OP_W-1:0] OP_NOP  = 6'b000000;
  localparam logic [OP_W-1:0] OP_ADD  = 6'b000100;
  localparam logic [OP_W-1:0] OP_SUB  = 6'b000110;
  localparam logic [OP_W-1:0] OP_AND  = 6'b001000;
  localparam logic [OP_W-1:0] OP_OR   = 6'b001001;
  localparam logic [OP_W-1:0] OP_XOR  = 6'b001010;
  localparam logic [OP_W-1:0] OP_SHL  = 6'b001100;
  localparam logic [OP_W-1:0] OP_SHRL = 6'b001110;
  localparam logic [OP_W-1:0] OP_SHRA = 6'b001111;
  localparam logic [OP_W-1:0] OP_SEQ  = 6'b010000;
  localparam logic [OP_W-1:0] OP_SNE  = 6'b010010;
  localparam logic [OP_W-1:0] OP_SLT  = 6'b010100;
  localparam logic [OP_W-1:0] OP_SLE  = 6'b010110;
  localparam logic [OP_W-1:0] OP_SGT  = 6'b011000;
  localparam logic [OP_W-1:0] OP_SGE  = 6'b011010;
  localparam logic [OP_W-1:0] OP_HIGH = 6'b011011;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ARITH, SEL_LOGIC, SEL_SHIFT, SEL_CMP, SEL_HIGH
  } resSel_e;

  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR } logicFn_e;
  typedef enum logic [1:0] { SH_LEFT, SH_RLOG, SH_RARITH } shiftFn_e;
  typedef enum logic [2:0] { CMP_EQ, CMP_NE, CMP_LT, CMP_LE, CMP_GT, CMP_GE } cmpKind_e;

  typedef struct packed {
    resSel_e  sel;
    logic     subtract;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
    cmpKind_e cmp;
    logic     ovfEn;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ri_ctrl.sv
module alu_ri_ctrl
  import alu_ri_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.sel      = SEL_ZERO;
    ctrl.logicFn  = LG_AND;
    ctrl.shiftFn  = SH_LEFT;
    ctrl.cmp      = CMP_EQ;
    case (opCode)
      OP_ADD:  begin ctrl.sel = SEL_ARITH; ctrl.ovfEn = 1'b1; end
      OP_SUB:  begin ctrl.sel = SEL_ARITH; ctrl.ovfEn = 1'b1; ctrl.subtract = 1'b1; end
      OP_AND:  begin ctrl.sel = SEL_LOGIC; ctrl.logicFn = LG_AND; end
      OP_OR:   begin ctrl.sel = SEL_LOGIC; ctrl.logicFn = LG_OR;  end
      OP_XOR:  begin ctrl.sel = SEL_LOGIC; ctrl.logicFn = LG_XOR; end
      OP_SHL:  begin ctrl.sel = SEL_SHIFT; ctrl.shiftFn = SH_LEFT;   end
      OP_SHRL: begin ctrl.sel = SEL_SHIFT; ctrl.shiftFn = SH_RLOG;   end
      OP_SHRA: begin ctrl.sel = SEL_SHIFT; ctrl.shiftFn = SH_RARITH; end
      OP_SEQ:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_EQ; end
      OP_SNE:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_NE; end
      OP_SLT:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_LT; end
      OP_SLE:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_LE; end
      OP_SGT:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_GT; end
      OP_SGE:  begin ctrl.sel = SEL_CMP; ctrl.cmp = CMP_GE; end
      OP_HIGH: begin ctrl.sel = SEL_HIGH; end
      default: ctrl.sel = SEL_ZERO; // no-op and undefined codes
    endcase
  end

endmodule

// File: rtl/alu_ri_dp.sv
module alu_ri_dp
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  aluCtrl_t            ctrl,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  output logic [DATA_W-1:0]   res,
  output logic                ovf
);

  localparam int SH_W   = $clog2(DATA_W);
  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;

  logic [DATA_W-1:0] arithRes, logicRes, shiftRes, highRes;
  logic [SH_W-1:0]   shAmt;
  logic              isEq, isLt, cmpHit, rawOvf;

  assign shAmt = opB[SH_W-1:0];

  // Adder / subtractor with signed overflow detection
  always_comb begin
    arithRes = ctrl.subtract ? (opA - opB) : (opA + opB);
    if (ctrl.subtract)
      rawOvf = (opA[MSB] != opB[MSB]) && (arithRes[MSB] != opA[MSB]);
    else
      rawOvf = (opA[MSB] == opB[MSB]) && (arithRes[MSB] != opA[MSB]);
  end

  always_comb begin
    case (ctrl.logicFn)
      LG_OR:   logicRes = opA | opB;
      LG_XOR:  logicRes = opA ^ opB;
      default: logicRes = opA & opB;
    endcase
  end

  always_comb begin
    case (ctrl.shiftFn)
      SH_RLOG:   shiftRes = opA >> shAmt;
      SH_RARITH: shiftRes = DATA_W'($signed(opA) >>> shAmt);
      default:   shiftRes = opA << shAmt;
    endcase
  end

  assign isEq = (opA == opB);
  assign isLt = ($signed(opA) < $signed(opB));

  always_comb begin
    case (ctrl.cmp)
      CMP_NE:  cmpHit = !isEq;
      CMP_LT:  cmpHit = isLt;
      CMP_LE:  cmpHit = isLt || isEq;
      CMP_GT:  cmpHit = !(isLt || isEq);
      CMP_GE:  cmpHit = !isLt;
      default: cmpHit = isEq;
    endcase
  end

  assign highRes = {opB[HALF_W-1:0], {(DATA_W-HALF_W){1'b0}}};

  always_comb begin
    case (ctrl.sel)
      SEL_ARITH: res = arithRes;
      SEL_LOGIC: res = logicRes;
      SEL_SHIFT: res = shiftRes;
      SEL_CMP:   res = {{(DATA_W-1){1'b0}}, cmpHit};
      SEL_HIGH:  res = highRes;
      default:   res = '0;
    endcase
    ovf = ctrl.ovfEn && (ctrl.sel == SEL_ARITH) && rawOvf;
  end

endmodule

// File: rtl/alu_ri_top.sv
module alu_ri_top
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              overflow
);

  aluCtrl_t          ctrl;
  logic [DATA_W-1:0] dpRes;
  logic              dpOvf;

  alu_ri_ctrl ctrl_i (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_ri_dp #(.DATA_W(DATA_W)) dp_i (
    .ctrl (ctrl),
    .opA  (operandA),
    .opB  (operandB),
    .res  (dpRes),
    .ovf  (dpOvf)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result   <= dpRes;
        overflow <= dpOvf;
      end
    end
  end

endmodule

// File: rtl/alu_ri_checker.sv
module alu_ri_checker
  import alu_ri_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opCode,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              overflow
);

  logic isCmpOp, isArithOp;
  assign isCmpOp = (opCode == OP_SEQ) || (opCode == OP_SNE) || (opCode == OP_SLT) ||
                   (opCode == OP_SLE) || (opCode == OP_SGT) || (opCode == OP_SGE);
  assign isArithOp = (opCode == OP_ADD) || (opCode == OP_SUB);

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(overflow)));

  assert_cmp_is_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isCmpOp) |=> (result[DATA_W-1:1] == '0));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isArithOp) |=> !overflow);

  assert_high_low_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == OP_HIGH) |=> (result[DATA_W/2-1:0] == '0));

  assert_nop_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == OP_NOP) |=> (result == '0 && !overflow));

endmodule

bind alu_ri_top alu_ri_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .outValid (outValid),
  .result   (result),
  .overflow (overflow)
);

// File: tb/alu_ri_top_tb_top.sv
module alu_ri_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [5:0]  opCode = '0;
  logic [31:0] operandA = '0;
  logic [31:0] operandB = '0;
  logic        outValid;
  logic [31:0] result;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic [5:0]  op;
  } exp_t;

  exp_t expQ[$];
  logic [31:0] lastRes = '0;
  logic        lastOvf = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  alu_ri_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .operandA(operandA), .operandB(operandB),
    .outValid(outValid), .result(result), .overflow(overflow)
  );

  function automatic string reqOf(input logic [5:0] op);
    case (op)
      6'b000100, 6'b000110: return "R1";
      6'b001000, 6'b001001, 6'b001010: return "R3";
      6'b001100, 6'b001110: return "R4";
      6'b001111: return "R5";
      6'b010000, 6'b010010, 6'b010100, 6'b010110, 6'b011000, 6'b011010: return "R6";
      6'b011011: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Independent reference model built from the requirements
  function automatic exp_t model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint s;
    e.op = op; e.ovf = 1'b0; e.res = '0;
    case (op)
      6'b000100: begin s = sa + sb; e.res = s[31:0]; e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      6'b000110: begin s = sa - sb; e.res = s[31:0]; e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      6'b001000: e.res = a & b;
      6'b001001: e.res = a | b;
      6'b001010: e.res = a ^ b;
      6'b001100: e.res = a << b[4:0];
      6'b001110: e.res = a >> b[4:0];
      6'b001111: begin
        s = sa >>> b[4:0];
        e.res = s[31:0];
      end
      6'b010000: e.res = {31'b0, sa == sb};
      6'b010010: e.res = {31'b0, sa != sb};
      6'b010100: e.res = {31'b0, sa <  sb};
      6'b010110: e.res = {31'b0, sa <= sb};
      6'b011000: e.res = {31'b0, sa >  sb};
      6'b011010: e.res = {31'b0, sa >= sb};
      6'b011011: e.res = {b[15:0], 16'h0000};
      default:   e.res = '0;
    endcase
    return e;
  endfunction

  task automatic send(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid  = 1'b1;
    opCode   = op;
    operandA = a;
    operandB = b;
    expQ.push_back(model(op, a, b));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid  = 1'b0;
      opCode   = 6'h3f;
      operandA = 32'hdead_beef;
      operandB = 32'h1234_5678;
    end
  endtask

  // Monitor / scoreboard: outputs registered at posedge, read at negedge (R9)
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (outValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R9: outValid=1 with no pending request, actual res=%h expected none", result);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (result !== e.res) begin
            fails++;
            $display("FAIL %s: op=%b result actual=%h expected=%h", reqOf(e.op), e.op, result, e.res);
          end
          checks++;
          if (overflow !== e.ovf) begin
            fails++;
            $display("FAIL R2: op=%b overflow actual=%b expected=%b", e.op, overflow, e.ovf);
          end
        end
        lastRes = result;
        lastOvf = overflow;
      end else begin
        checks++; // R10 hold while idle
        if (result !== lastRes || overflow !== lastOvf) begin
          fails++;
          $display("FAIL R10: idle output moved, actual=%h/%b expected=%h/%b",
                   result, overflow, lastRes, lastOvf);
        end
      end
    end
  end

  localparam logic [5:0] OPS [18] = '{
    6'b000000, 6'b000100, 6'b000110, 6'b001000, 6'b001001, 6'b001010,
    6'b001100, 6'b001110, 6'b001111, 6'b010000, 6'b010010, 6'b010100,
    6'b010110, 6'b011000, 6'b011010, 6'b011011, 6'b111111, 6'b000001 };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R9: watchdog expired, actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (outValid !== 1'b0 || result !== 32'h0 || overflow !== 1'b0) begin
      fails++;
      $display("FAIL R10: reset state actual=%b/%h/%b expected=0/0/0", outValid, result, overflow);
    end
    rstN = 1'b1;
    idle(2);

    // R1 / R2: wrap and signed overflow corners
    send(6'b000100, 32'h7fff_ffff, 32'h0000_0001); // overflow
    send(6'b000100, 32'hffff_ffff, 32'h0000_0001); // wrap, no overflow
    send(6'b000100, 32'h8000_0000, 32'h8000_0000); // negative overflow
    send(6'b000110, 32'h8000_0000, 32'h0000_0001); // overflow
    send(6'b000110, 32'h0000_0000, 32'h8000_0000); // overflow
    send(6'b000110, 32'h0000_0005, 32'h0000_0007); // -2
    // R3 logic
    send(6'b001000, 32'hf0f0_1234, 32'h0ff0_ffff);
    send(6'b001001, 32'hf0f0_0000, 32'h0000_0f0f);
    send(6'b001010, 32'haaaa_5555, 32'hffff_0000);
    // R4 shifts, upper bits of B ignored
    send(6'b001100, 32'h0000_0001, 32'hffff_ffe4); // amount 4
    send(6'b001110, 32'h8000_0000, 32'h0000_003f); // amount 31
    send(6'b001100, 32'h1234_5678, 32'h0000_0020); // amount 0
    // R5 arithmetic shift
    send(6'b001111, 32'h8000_0010, 32'h0000_0004);
    send(6'b001111, 32'h7000_0000, 32'h0000_001f);
    // R6 signed compares
    send(6'b010100, 32'hffff_ffff, 32'h0000_0001);
    send(6'b011000, 32'hffff_ffff, 32'h0000_0001);
    send(6'b010110, 32'h0000_0009, 32'h0000_0009);
    send(6'b011010, 32'h8000_0000, 32'h7fff_ffff);
    send(6'b010000, 32'h1234_5678, 32'h1234_5678);
    send(6'b010010, 32'h1234_5678, 32'h1234_5678);
    // R7 upper-half load
    send(6'b011011, 32'hffff_ffff, 32'hffff_abcd);
    // R8 no-op and unknown codes
    send(6'b000000, 32'h7fff_ffff, 32'h7fff_ffff);
    send(6'b111111, 32'h7fff_ffff, 32'h0000_0001);
    idle(3); // R10 hold
    send(6'b000101, 32'h8000_0000, 32'h8000_0000);

    // mixed traffic with gaps
    for (int k = 0; k < 400; k++) begin
      logic [5:0] op;
      op = OPS[$urandom_range(0, 17)];
      send(op, $urandom(), ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 40)) : $urandom());
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
    end
    idle(3);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: results missing, actual pending=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule